// File: doc/BRIEF.md
# Colour Palette Register Port

This block is the host-side register interface of a 256-entry colour palette. Each entry holds three 6-bit colour components: red, green and blue. A host reaches the palette through four byte-wide registers chosen by a 2-bit select: a write index, a read index, a data port and a pixel mask. One internal component counter picks red, then green, then blue for successive data-port accesses. After blue, the counter returns to red and the index in use moves to the next entry. A host can therefore load or dump whole entries by streaming bytes through one address.

A second, independent lookup port serves the pixel path. A pixel index is ANDed with the pixel mask, and the selected entry's 18-bit colour is presented one clock later. Host accesses are sampled on the rising clock edge. Read data is registered and appears after the edge that sampled the read strobe.

Top module: `pal_dac_port`

## Requirements
- R1: After reset the write index and read index read back as 0x00, the pixel mask reads back as 0xFF, `rd_data` is 0x00, `lk_color` is 0 and the component counter points at red.
- R2: With `reg_sel`=0 (write index) or `reg_sel`=1 (read index), a write loads the full 8-bit value and a read returns it.
- R3: With `reg_sel`=2 (data), each write stores `wr_data[5:0]` into the component the counter selects in the entry at the write index. Components go in the order red, green, blue. After blue the counter returns to red and the write index increments, wrapping from 255 to 0.
- R4: Writing either index register returns the component counter to red.
- R5: A data-port read returns {2'b00, component} for the component the counter selects in the entry at the read index. It advances the counter and read index in the same way as R3, and the read index wraps from 255 to 0.
- R6: Reading the write index, read index or mask register leaves the counter and both indices unchanged.
- R7: With `reg_sel`=3, the pixel mask is a plain 8-bit register that can be written and read back.
- R8: `lk_color` = {red[17:12], green[11:6], blue[5:0]} of entry (`lk_pix` & mask), registered at each clock edge. A data write in the same cycle becomes visible only at the following edge.
- R9: When `rd_en` and `wr_en` are both high, only the write takes effect and `rd_data` holds its value.
- R10: `rd_data` changes only at an edge where a read is accepted. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 write index, 1 read index, 2 data, 3 mask |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| lk_pix | input | 8 | Pixel index for lookup |
| lk_color | output | 18 | Looked-up colour, red in the top bits |

## Verification
A host data write and a pixel lookup can hit the same entry in the same cycle. The bench holds `lk_pix` on an entry and writes that entry's red component through the data port. It then expects the old colour after that edge and the new colour one edge later. Simultaneous read and write strobes are also driven together on an index register. The bench checks that `rd_data` holds and that the write landed.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int NCOMP = 3;

  typedef enum logic [1:0] {
    SEL_WIDX = 2'd0,
    SEL_RIDX = 2'd1,
    SEL_DATA = 2'd2,
    SEL_MASK = 2'd3
  } pal_sel_e;

  typedef enum logic [1:0] {
    C_RED = 2'd0,
    C_GRN = 2'd1,
    C_BLU = 2'd2
  } comp_e;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_w,
  input  logic             load_r,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step_w,
  input  logic             step_r,
  output logic [IDX_W-1:0] widx,
  output logic [IDX_W-1:0] ridx,
  output comp_e            comp
);
  logic [IDX_W-1:0] widx_q, widx_d, ridx_q, ridx_d;
  comp_e            comp_q, comp_d;
  logic             en;
  logic             last;

  assign last = (comp_q == C_BLU);
  assign en   = load_w | load_r | step_w | step_r;

  always_comb begin
    widx_d = widx_q;
    ridx_d = ridx_q;
    comp_d = comp_q;
    if (load_w || load_r) begin
      comp_d = C_RED;
      if (load_w) widx_d = load_val;
      if (load_r) ridx_d = load_val;
    end else if (step_w || step_r) begin
      comp_d = last ? C_RED : comp_e'(comp_q + 2'd1);
      if (step_w && last) widx_d = widx_q + 1'b1;
      if (step_r && last) ridx_d = ridx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_q <= '0;
      ridx_q <= '0;
      comp_q <= C_RED;
    end else if (en) begin
      widx_q <= widx_d;
      ridx_q <= ridx_d;
      comp_q <= comp_d;
    end
  end

  assign widx = widx_q;
  assign ridx = ridx_q;
  assign comp = comp_q;
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        waddr,
  input  comp_e                   wcomp,
  input  logic [COMP_W-1:0]       wval,
  input  logic [IDX_W-1:0]        raddr,
  input  comp_e                   rcomp,
  output logic [COMP_W-1:0]       rval,
  input  logic [IDX_W-1:0]        lk_addr,
  output logic [NCOMP*COMP_W-1:0] lk_color
);
  localparam int NENT = 1 << IDX_W;

  logic [COMP_W-1:0] rd_vals [NCOMP];

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic [COMP_W-1:0] arr [NENT];
    logic [COMP_W-1:0] lk_q;
    logic              wsel;

    assign wsel = we && (wcomp == comp_e'(c));

    always_ff @(posedge clk) begin
      if (wsel) arr[waddr] <= wval;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lk_q <= '0;
      else        lk_q <= arr[lk_addr];
    end

    assign rd_vals[c] = arr[raddr];
    assign lk_color[(NCOMP-1-c)*COMP_W +: COMP_W] = lk_q;
  end

  always_comb begin
    case (rcomp)
      C_RED:   rval = rd_vals[0];
      C_GRN:   rval = rd_vals[1];
      C_BLU:   rval = rd_vals[2];
      default: rval = '0;
    endcase
  end
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
  import pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              reg_sel,
  input  logic                    rd_en,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_data,
  output logic [IDX_W-1:0]        rd_data,
  input  logic [IDX_W-1:0]        lk_pix,
  output logic [NCOMP*COMP_W-1:0] lk_color
);
  localparam int PAD_W = IDX_W - COMP_W;

  pal_sel_e          sel;
  logic              rd_acc;
  logic              load_w, load_r, step_w, step_r, mask_we;
  logic [IDX_W-1:0]  widx, ridx;
  comp_e             comp;
  logic [IDX_W-1:0]  mask_q;
  logic [IDX_W-1:0]  rdata_q, rdata_d;
  logic [COMP_W-1:0] rval;

  assign sel     = pal_sel_e'(reg_sel);
  assign rd_acc  = rd_en & ~wr_en;
  assign load_w  = wr_en & (sel == SEL_WIDX);
  assign load_r  = wr_en & (sel == SEL_RIDX);
  assign step_w  = wr_en & (sel == SEL_DATA);
  assign mask_we = wr_en & (sel == SEL_MASK);
  assign step_r  = rd_acc & (sel == SEL_DATA);

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .load_w(load_w), .load_r(load_r), .load_val(wr_data),
    .step_w(step_w), .step_r(step_r),
    .widx(widx), .ridx(ridx), .comp(comp)
  );

  pal_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(step_w), .waddr(widx), .wcomp(comp), .wval(wr_data[COMP_W-1:0]),
    .raddr(ridx), .rcomp(comp), .rval(rval),
    .lk_addr(lk_pix & mask_q), .lk_color(lk_color)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= wr_data;
  end

  always_comb begin
    case (sel)
      SEL_WIDX: rdata_d = widx;
      SEL_RIDX: rdata_d = ridx;
      SEL_DATA: rdata_d = {{PAD_W{1'b0}}, rval};
      default:  rdata_d = mask_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_acc) rdata_q <= rdata_d;
  end

  assign rd_data = rdata_q;
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_sel,
  input logic             rd_en,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_data,
  input logic [IDX_W-1:0] rd_data,
  input logic [IDX_W-1:0] widx,
  input logic [IDX_W-1:0] ridx,
  input comp_e            comp
);
  // R3: counter never leaves red/green/blue
  a_r3_comp_legal: assert property (@(posedge clk) disable iff (!rst_n)
    comp != comp_e'(2'd3));

  // R3: blue data write wraps to red and bumps write index
  a_r3_wrap_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd2 && comp == C_BLU) |=>
      (comp == C_RED && widx == IDX_W'($past(widx) + 1'b1)));

  // R4: index write returns counter to red
  a_r4_index_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (reg_sel == 2'd0 || reg_sel == 2'd1)) |=> (comp == C_RED));

  // R5: data-port read has upper bits clear
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && reg_sel == 2'd2) |=> (rd_data[IDX_W-1:6] == '0));

  // R6: non-data reads leave sequencing alone
  a_r6_reg_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && reg_sel != 2'd2) |=>
      ($stable(comp) && $stable(widx) && $stable(ridx)));

  // R9: both strobes: read data held
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> $stable(rd_data));

  // R10: no read, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en) |=> $stable(rd_data));
endmodule

bind pal_dac_port pal_dac_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .widx(widx), .ridx(ridx), .comp(comp)
);

// File: tb/pal_dac_port_tb.sv
module pal_dac_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'd0;
  logic [7:0]  rd_data;
  logic [7:0]  lk_pix = 8'd0;
  logic [17:0] lk_color;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pal_dac_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .lk_pix(lk_pix), .lk_color(lk_color)
  );

  typedef struct packed {
    logic [7:0] idx;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{8'h03, 8'h3F, 8'h00, 8'h15},
    '{8'h10, 8'hC1, 8'h82, 8'h43},
    '{8'h7E, 8'h2A, 8'hFF, 8'h01},
    '{8'h80, 8'h00, 8'h3F, 8'hAA},
    '{8'hA5, 8'h55, 8'h2B, 8'h3C},
    '{8'hF0, 8'h11, 8'h22, 8'h33}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] q);
    @(negedge clk);
    reg_sel = s; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] q, r0, g0, b0;
    logic [17:0] oldc;
    repeat (3) @(negedge clk);
    // R1: reset state at ports
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 lk_color", lk_color, 18'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(2'd0, q); chk("R1 widx", q, 8'h00);
    rd(2'd1, q); chk("R1 ridx", q, 8'h00);
    rd(2'd3, q); chk("R1 mask", q, 8'hFF);

    // R3: table walk, program entries
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, VECS[i].idx);
      wr(2'd2, VECS[i].r);
      wr(2'd2, VECS[i].g);
      wr(2'd2, VECS[i].b);
      rd(2'd0, q); chk("R3 widx advance", q, 8'(VECS[i].idx + 8'd1));
    end
    // R5/R8: read back through data port and lookup
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd1, VECS[i].idx);
      rd(2'd2, q); chk("R5 red", q, {2'b00, VECS[i].r[5:0]});
      rd(2'd2, q); chk("R5 green", q, {2'b00, VECS[i].g[5:0]});
      rd(2'd2, q); chk("R5 blue", q, {2'b00, VECS[i].b[5:0]});
      rd(2'd1, q); chk("R5 ridx advance", q, 8'(VECS[i].idx + 8'd1));
      @(negedge clk); lk_pix = VECS[i].idx;
      @(negedge clk);
      chk("R8 lookup", lk_color, {VECS[i].r[5:0], VECS[i].g[5:0], VECS[i].b[5:0]});
    end

    // R2: index registers full byte
    wr(2'd0, 8'hC7); rd(2'd0, q); chk("R2 widx", q, 8'hC7);
    wr(2'd1, 8'h5A); rd(2'd1, q); chk("R2 ridx", q, 8'h5A);

    // R3: write index wraps 255 -> 0
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h01); wr(2'd2, 8'h02); wr(2'd2, 8'h03);
    rd(2'd0, q); chk("R3 widx wrap", q, 8'h00);
    wr(2'd2, 8'h04); wr(2'd2, 8'h05); wr(2'd2, 8'h06);
    // R5: read index wraps 255 -> 0
    wr(2'd1, 8'hFF);
    rd(2'd2, q); rd(2'd2, q); rd(2'd2, q); chk("R5 blue of 255", q, 8'h03);
    rd(2'd1, q); chk("R5 ridx wrap", q, 8'h00);
    rd(2'd2, q); chk("R5 red of 0", q, 8'h04);

    // R4: index write returns counter to red
    wr(2'd0, 8'h10); wr(2'd2, 8'h2E);
    wr(2'd0, 8'h10); wr(2'd2, 8'h1D);
    wr(2'd1, 8'h10);
    rd(2'd2, q); chk("R4 red rewritten", q, 8'h1D);
    rd(2'd2, q); chk("R4 green kept", q, 8'h02);

    // R6: register reads do not disturb sequence
    wr(2'd1, 8'h7E);
    rd(2'd2, q); chk("R6 red", q, 8'h2A);
    rd(2'd0, q); rd(2'd1, q); chk("R6 ridx unchanged", q, 8'h7E);
    rd(2'd3, q);
    rd(2'd2, q); chk("R6 green after reg reads", q, 8'h3F);

    // R7: mask register and masked lookup
    wr(2'd3, 8'h0F); rd(2'd3, q); chk("R7 mask rw", q, 8'h0F);
    @(negedge clk); lk_pix = 8'hF3;
    @(negedge clk); chk("R7 masked lookup", lk_color, {6'h3F, 6'h00, 6'h15});
    wr(2'd3, 8'hFF);

    // R8: same-cycle data write and lookup of same entry
    @(negedge clk); lk_pix = 8'h03;
    @(negedge clk); oldc = lk_color;
    chk("R8 before write", oldc, {6'h3F, 6'h00, 6'h15});
    wr(2'd0, 8'h03);
    wr(2'd2, 8'h07);
    chk("R8 same edge sees old", lk_color, oldc);
    @(negedge clk); chk("R8 next edge sees new", lk_color, {6'h07, 6'h00, 6'h15});

    // R9/R10: both strobes
    rd(2'd3, q); chk("R10 mask read", q, 8'hFF);
    @(negedge clk);
    reg_sel = 2'd0; wr_data = 8'h77; rd_en = 1'b1; wr_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R9 rd_data held", rd_data, 8'hFF);
    @(negedge clk); chk("R10 idle hold", rd_data, 8'hFF);
    rd(2'd0, q); chk("R9 write landed", q, 8'h77);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule